// File: doc/BRIEF.md
# Scan-Mode ADC Channel Sequencer

This block drives an external analog-to-digital converter core through a repeated scan of a small channel group. A start bit begins the scan. Software can set it with a control write, and a one-cycle pulse on either the timer trigger input or the external trigger input also sets it. The sequencer then converts the selected channels one after another, beginning at the first channel of the chosen group. It stores each 10-bit result in the result register for that position in the group, named A, B, C or D. When a full pass completes it raises a done flag, and it raises an interrupt when interrupts are enabled. It then starts the next pass at once, without software, and keeps scanning for as long as the start bit stays at 1.

The converter handshake works as follows. The sequencer drives a one-cycle start pulse and a channel index. The converter later returns a one-cycle done pulse with the conversion value, after a latency of any length. If software clears the start bit while a conversion is outstanding, the scan stops and the late value is thrown away. Changes to the group or count fields take effect at the next pass boundary.

The control path is a three-state machine. IDLE waits for the start bit. LAUNCH issues the converter start pulse, and on the first position of a pass it latches the pass configuration. WAIT holds until the converter answers. The transitions are:
- IDLE→LAUNCH when the start bit is 1.
- LAUNCH→WAIT when the start bit is still 1.
- LAUNCH→IDLE when the start bit has been cleared.
- WAIT→LAUNCH on converter done. This moves to the next position, or wraps to position 0 at the end of a pass.
- WAIT→IDLE when the start bit has been cleared (abort).

Top module: `adc_scan_ctrl`

## Requirements
- R1: The start bit becomes 1 on a control write with `ctl_start`=1, on a `tmr_trig` pulse, or on an `ext_trig` pulse. Any of the three starts a scan. A control write with `ctl_start`=0 clears the bit.
- R2: Every pass begins at the group's first channel: 0 for group code 00, 4 for 01, 8 for 10. The reserved code 11 behaves as 00.
- R3: Count code n (2 bits) selects n+1 channels per pass. They are converted in ascending order from the first channel, so code 00 gives one channel and code 11 gives four.
- R4: The result returned for position p of the group (p = 0..3) is written into result register A, B, C or D respectively (`res_a`..`res_d`).
- R5: After the last channel of a pass is accepted, `done_flag` is 1. `irq` equals `done_flag` AND the interrupt enable. A `done_clr` pulse clears the flag, which drops `irq`. A pass end in the same cycle as a clear wins over the clear.
- R6: While the start bit stays 1, the next pass starts at the first channel with no software action.
- R7: After the start bit is cleared, a converter done that arrives later updates no result register, sets no done flag, and no further converter start is issued. A done that arrives while the start bit still reads 1 is accepted.
- R8: A group or count change written while scanning takes effect only at the next pass.
- R9: `cv_start` is a single-cycle pulse. No new start is issued until the outstanding conversion returns its done.
- R10: After reset, the start bit, done flag, irq, `cv_start` and all result registers are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_start | input | 1 | Start bit value written |
| ctl_grp | input | 2 | Group select written |
| ctl_cnt | input | 2 | Channel count code written |
| ctl_ie | input | 1 | Interrupt enable written |
| done_clr | input | 1 | Clears the done flag |
| tmr_trig | input | 1 | Timer trigger pulse |
| ext_trig | input | 1 | External trigger pulse |
| cv_done | input | 1 | Converter done pulse |
| cv_data | input | 10 | Converter result value |
| cv_start | output | 1 | Converter start pulse |
| cv_chan | output | 4 | Channel index for the converter |
| start_bit | output | 1 | Current start bit |
| done_flag | output | 1 | Pass-complete flag |
| irq | output | 1 | Interrupt request |
| res_a | output | 10 | Result register, position 0 |
| res_b | output | 10 | Result register, position 1 |
| res_c | output | 10 | Result register, position 2 |
| res_d | output | 10 | Result register, position 3 |

## Verification
The scan is exercised with three channels over two passes, started from software. This shows the wrap back to the first channel in continuous operation. A four-channel scan of group 01 started by the timer trigger checks the base offset, the full result register span, and that `irq` stays low with interrupts disabled. A single-channel scan of group 10 started by the external trigger runs three passes and checks that one position can repeat indefinitely. The reserved group code checks the fallback to base 0. A mid-scan configuration rewrite separates an immediate effect from a pass-boundary effect. A slow conversion cut off by clearing the start bit shows whether a late done is truly discarded.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
    localparam int DATA_W = 10;
    localparam int CHAN_W = 4;
    localparam int POS_N  = 4;
    localparam int POS_W  = $clog2(POS_N);

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_WAIT   = 2'd2
    } seq_state_t;

    function automatic logic [CHAN_W-1:0] group_base(input logic [1:0] grp);
        case (grp)
            2'b01:   group_base = CHAN_W'(4);
            2'b10:   group_base = CHAN_W'(8);
            default: group_base = '0;
        endcase
    endfunction
endpackage

// File: rtl/adc_scan_regs.sv
module adc_scan_regs
    import adc_scan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_we,
    input  logic       ctl_start,
    input  logic [1:0] ctl_grp,
    input  logic [1:0] ctl_cnt,
    input  logic       ctl_ie,
    input  logic       done_clr,
    input  logic       tmr_trig,
    input  logic       ext_trig,
    input  logic       pass_end,
    output logic       start_q,
    output logic [1:0] grp_q,
    output logic [1:0] cnt_q,
    output logic       done_q,
    output logic       irq
);
    logic ie_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            grp_q   <= 2'b00;
            cnt_q   <= 2'b00;
            ie_q    <= 1'b0;
        end else begin
            if (ctl_we) begin
                start_q <= ctl_start;
                grp_q   <= ctl_grp;
                cnt_q   <= ctl_cnt;
                ie_q    <= ctl_ie;
            end
            if (tmr_trig || ext_trig)
                start_q <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            done_q <= 1'b0;
        else if (pass_end)
            done_q <= 1'b1;
        else if (done_clr)
            done_q <= 1'b0;
    end

    assign irq = done_q & ie_q;

    p_pass_sets_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pass_end |=> done_q);
    p_clear_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_clr && !pass_end) |=> !done_q);
    p_trig_sets_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_trig || ext_trig) |=> start_q);
endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
    import adc_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_q,
    input  logic [1:0]        grp_q,
    input  logic [1:0]        cnt_q,
    input  logic              cv_done,
    output logic              cv_start,
    output logic [CHAN_W-1:0] cv_chan,
    output logic              res_we,
    output logic [POS_W-1:0]  res_pos,
    output logic              pass_end
);
    seq_state_t        state, state_nx;
    logic [POS_W-1:0]  pos;
    logic [CHAN_W-1:0] act_base;
    logic [POS_W-1:0]  act_last;
    logic              at_last;

    assign at_last = (pos == act_last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start_q) state_nx = ST_LAUNCH;
            ST_LAUNCH: state_nx = start_q ? ST_WAIT : ST_IDLE;
            ST_WAIT: begin
                if (!start_q)     state_nx = ST_IDLE;
                else if (cv_done) state_nx = ST_LAUNCH;
            end
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos      <= '0;
            act_base <= '0;
            act_last <= '0;
        end else begin
            unique case (state)
                ST_IDLE: pos <= '0;
                ST_LAUNCH: begin
                    if (start_q && pos == '0) begin
                        act_base <= group_base(grp_q);
                        act_last <= POS_W'(cnt_q);
                    end
                end
                ST_WAIT: begin
                    if (!start_q)     pos <= '0;
                    else if (cv_done) pos <= at_last ? '0 : pos + 1'b1;
                end
                default: pos <= '0;
            endcase
        end
    end

    always_comb begin
        cv_start = 1'b0;
        res_we   = 1'b0;
        pass_end = 1'b0;
        res_pos  = pos;
        cv_chan  = ((pos == '0) ? group_base(grp_q) : act_base) + CHAN_W'(pos);
        unique case (state)
            ST_IDLE:   ;
            ST_LAUNCH: cv_start = start_q;
            ST_WAIT: begin
                res_we   = start_q && cv_done;
                pass_end = start_q && cv_done && at_last;
            end
            default:   ;
        endcase
    end

    p_start_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cv_start |=> !cv_start);
    p_pos_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> (pos <= act_last));
    p_launch_to_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cv_start |=> (state == ST_WAIT || !start_q));
endmodule

// File: rtl/adc_scan_results.sv
module adc_scan_results
    import adc_scan_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [POS_W-1:0]       pos,
    input  logic [DATA_W-1:0]      data,
    output logic [POS_N*DATA_W-1:0] res_flat
);
    for (genvar g = 0; g < POS_N; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                res_flat[g*DATA_W +: DATA_W] <= '0;
            else if (we && pos == POS_W'(g))
                res_flat[g*DATA_W +: DATA_W] <= data;
        end
    end

    p_hold_without_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(res_flat));
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
    import adc_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic              ctl_start,
    input  logic [1:0]        ctl_grp,
    input  logic [1:0]        ctl_cnt,
    input  logic              ctl_ie,
    input  logic              done_clr,
    input  logic              tmr_trig,
    input  logic              ext_trig,
    input  logic              cv_done,
    input  logic [9:0]        cv_data,
    output logic              cv_start,
    output logic [3:0]        cv_chan,
    output logic              start_bit,
    output logic              done_flag,
    output logic              irq,
    output logic [9:0]        res_a,
    output logic [9:0]        res_b,
    output logic [9:0]        res_c,
    output logic [9:0]        res_d
);
    logic [1:0]              grp_q, cnt_q;
    logic                    res_we, pass_end;
    logic [POS_W-1:0]        res_pos;
    logic [POS_N*DATA_W-1:0] res_flat;

    adc_scan_regs u_regs (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_start(ctl_start),
        .ctl_grp(ctl_grp), .ctl_cnt(ctl_cnt), .ctl_ie(ctl_ie),
        .done_clr(done_clr), .tmr_trig(tmr_trig), .ext_trig(ext_trig),
        .pass_end(pass_end), .start_q(start_bit), .grp_q(grp_q),
        .cnt_q(cnt_q), .done_q(done_flag), .irq(irq)
    );

    adc_scan_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start_q(start_bit), .grp_q(grp_q),
        .cnt_q(cnt_q), .cv_done(cv_done), .cv_start(cv_start),
        .cv_chan(cv_chan), .res_we(res_we), .res_pos(res_pos),
        .pass_end(pass_end)
    );

    adc_scan_results u_res (
        .clk(clk), .rst_n(rst_n), .we(res_we), .pos(res_pos),
        .data(cv_data), .res_flat(res_flat)
    );

    assign res_a = res_flat[0*DATA_W +: DATA_W];
    assign res_b = res_flat[1*DATA_W +: DATA_W];
    assign res_c = res_flat[2*DATA_W +: DATA_W];
    assign res_d = res_flat[3*DATA_W +: DATA_W];

    p_no_start_when_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_bit && $past(!start_bit)) |-> !cv_start);
endmodule

// File: tb/sim_adc_scan_ctrl.sv
module sim_adc_scan_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 0, ctl_start = 0, ctl_ie = 0, done_clr = 0;
    logic [1:0] ctl_grp = 0, ctl_cnt = 0;
    logic       tmr_trig = 0, ext_trig = 0;
    logic       cv_done = 0;
    logic [9:0] cv_data = 0;
    logic       cv_start, start_bit, done_flag, irq;
    logic [3:0] cv_chan;
    logic [9:0] res_a, res_b, res_c, res_d;

    int errors = 0, checks = 0;
    logic [3:0] exp_q[$];
    bit   ignore_res = 0;
    int   lat_force = 0;

    always #2 clk = ~clk;

    adc_scan_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_start(ctl_start),
        .ctl_grp(ctl_grp), .ctl_cnt(ctl_cnt), .ctl_ie(ctl_ie),
        .done_clr(done_clr), .tmr_trig(tmr_trig), .ext_trig(ext_trig),
        .cv_done(cv_done), .cv_data(cv_data), .cv_start(cv_start),
        .cv_chan(cv_chan), .start_bit(start_bit), .done_flag(done_flag),
        .irq(irq), .res_a(res_a), .res_b(res_b), .res_c(res_c), .res_d(res_d)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int res_at(input int p);
        case (p)
            0: return int'(res_a);
            1: return int'(res_b);
            2: return int'(res_c);
            default: return int'(res_d);
        endcase
    endfunction

    // converter model with variable latency
    int       nconv = 0, cnt_lat = 0;
    bit       busy = 0;
    logic [3:0] cur_chan = 0;
    always @(posedge clk) begin
        cv_done <= 1'b0;
        if (busy) begin
            if (cnt_lat == 0) begin
                cv_done <= 1'b1;
                cv_data <= 10'(cur_chan * 37 + nconv * 5 + 1);
                busy    <= 1'b0;
            end else cnt_lat <= cnt_lat - 1;
        end else if (cv_start) begin
            busy     <= 1'b1;
            cur_chan <= cv_chan;
            nconv    <= nconv + 1;
            cnt_lat  <= (lat_force > 0) ? lat_force : (nconv % 3);
        end
    end

    // monitor: scoreboard on channel order and result writes
    bit         prev_start = 0, pend = 0;
    int         pend_pos = 0, pend_data = 0;
    logic [3:0] last_chan = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (pend) begin
                chk("R4 result register", res_at(pend_pos), pend_data);
                pend = 0;
            end
            if (cv_start) begin
                if (prev_start) chk("R9 start pulse width", 2, 1);
                if (exp_q.size() == 0) chk("R7 unexpected converter start", int'(cv_chan), -1);
                else chk("R3 channel order", int'(cv_chan), int'(exp_q.pop_front()));
                last_chan = cv_chan;
            end
            if (cv_done && !ignore_res) begin
                pend = 1;
                pend_pos = int'(last_chan) % 4;
                pend_data = int'(cv_data);
            end
            prev_start = cv_start;
        end
    end

    task automatic wr(input bit st, input logic [1:0] g, input logic [1:0] c, input bit ie);
        @(negedge clk);
        ctl_we = 1; ctl_start = st; ctl_grp = g; ctl_cnt = c; ctl_ie = ie;
        @(negedge clk);
        ctl_we = 0;
    endtask

    task automatic clr_done();
        @(negedge clk); done_clr = 1;
        @(negedge clk); done_clr = 0;
    endtask

    task automatic push_scan(input int base, input int n, input int passes);
        for (int p = 0; p < passes; p++)
            for (int i = 0; i < n; i++) exp_q.push_back(4'(base + i));
    endtask

    // stop by clearing start in the cycle the final done is presented
    task automatic stop_at_last(input logic [1:0] g, input logic [1:0] c, input bit ie);
        do begin @(negedge clk); #0.5; end while (exp_q.size() != 0 || !cv_done);
        ctl_we = 1; ctl_start = 0; ctl_grp = g; ctl_cnt = c; ctl_ie = ie;
        @(negedge clk); ctl_we = 0;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10 reset state
        chk("R10 start_bit", start_bit, 0);
        chk("R10 done_flag", done_flag, 0);
        chk("R10 irq", irq, 0);
        chk("R10 cv_start", cv_start, 0);
        chk("R10 results", int'(res_a | res_b | res_c | res_d), 0);

        // R6 / R1: software start, group 00, three channels, two passes, irq enabled
        push_scan(0, 3, 2);
        wr(1, 2'b00, 2'b10, 1);
        chk("R1 software write sets start", start_bit, 1);
        stop_at_last(2'b00, 2'b10, 1);
        chk("R6 all passes consumed", exp_q.size(), 0);
        chk("R5 done after pass", done_flag, 1);
        chk("R5 irq with enable", irq, 1);
        chk("R1 write clears start", start_bit, 0);
        clr_done();
        chk("R5 done cleared", done_flag, 0);
        chk("R5 irq falls", irq, 0);

        // R2: timer trigger, group 01, four channels, irq disabled
        wr(0, 2'b01, 2'b11, 0);
        push_scan(4, 4, 1);
        @(negedge clk); tmr_trig = 1; @(negedge clk); tmr_trig = 0;
        chk("R1 timer trigger sets start", start_bit, 1);
        stop_at_last(2'b01, 2'b11, 0);
        chk("R5 done after four channel pass", done_flag, 1);
        chk("R5 irq masked", irq, 0);
        clr_done();

        // R2: external trigger, group 10, single channel, three passes
        wr(0, 2'b10, 2'b00, 1);
        push_scan(8, 1, 3);
        @(negedge clk); ext_trig = 1; @(negedge clk); ext_trig = 0;
        chk("R1 external trigger sets start", start_bit, 1);
        stop_at_last(2'b10, 2'b00, 1);
        chk("R5 single channel done", done_flag, 1);
        clr_done();

        // R2: reserved group 11 falls back to base 0, two channels
        push_scan(0, 2, 1);
        wr(1, 2'b11, 2'b01, 0);
        stop_at_last(2'b11, 2'b01, 0);
        chk("R2 reserved group done", done_flag, 1);
        clr_done();

        // R8: config change mid-pass applies at next pass
        exp_q.push_back(4'd0); exp_q.push_back(4'd1); exp_q.push_back(4'd4);
        lat_force = 4;
        wr(1, 2'b00, 2'b01, 0);
        do @(negedge clk); while (exp_q.size() != 2);
        wr(1, 2'b01, 2'b00, 0);
        lat_force = 0;
        stop_at_last(2'b01, 2'b00, 0);
        chk("R8 all expected starts seen", exp_q.size(), 0);
        clr_done();

        // R7: abort during a slow conversion
        begin
            int before_a;
            before_a = int'(res_a);
            lat_force = 8;
            exp_q.push_back(4'd0);
            wr(1, 2'b00, 2'b11, 0);
            do @(negedge clk); while (exp_q.size() != 0);
            ignore_res = 1;
            wr(0, 2'b00, 2'b11, 0);
            repeat (20) @(negedge clk);
            chk("R7 start cleared", start_bit, 0);
            chk("R7 late result discarded", int'(res_a), before_a);
            chk("R7 no done after abort", done_flag, 0);
            ignore_res = 0;
            lat_force = 0;
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule